// File: doc/BRIEF.md
# Multi-format TDM/I2S serial audio transmitter

This block turns a stream of parallel audio samples into a three-wire serial audio link in master mode: a bit clock divided down from the system clock, a word-select / frame-sync line and a serial data line. One shifter and one frame counter serve every framing convention: two-slot I2S, left-justified, and the short-sync PCM modes A and B. The same conventions extend to TDM frames of 4, 6 or 8 slots.

Samples arrive on a valid/ready stream, one word per slot in slot order. At each slot start the block loads the next word. It aligns the word to the configured data length and shifts it out MSB-first or LSB-first. Bits past the end of the data are filled with zeros, and bits beyond the slot length are dropped. If no word is offered when a slot begins, the slot is sent as silence and a one-cycle underrun pulse is raised. Configuration is static: it is changed only while reset is held.

Top module: `tdm_serial_tx`

## Requirements
- R1: While reset is asserted, `bclk` equals `cfg_bclk_inv`, and `sd`, `ws`, `s_ready` and `underrun` are 0.
- R2: The internal bit clock stays high for `cfg_div+1` system cycles and low for `cfg_div+1` cycles. `sd` and `ws` change only in the system cycle in which that clock falls, so they are stable while it is high. The `bclk` pin carries the internal clock XOR `cfg_bclk_inv`.
- R3: With `cfg_fmt`=0 (I2S), `ws` is 0 during the first half of the frame's slots and 1 during the second half. It takes each new value one bit period before the MSB of the slot that begins the half.
- R4: With `cfg_fmt`=1 (left-justified), `ws` follows the same half-frame levels as R3 but changes in the same bit period as that slot's first data bit.
- R5: With `cfg_fmt`=2 (PCM A), `ws` is a one-bit-period high pulse in the last bit of the last slot, which is the bit before the MSB of slot 0. `ws` is low elsewhere.
- R6: With `cfg_fmt`=3 (PCM B), `ws` is a one-bit-period high pulse together with the first bit of slot 0, and low elsewhere.
- R7: The data length code `cfg_dlen` (0,1,2,3 → 16,20,24,32 bits) selects how many low bits of `s_data` form the two's-complement sample; higher bits of `s_data` are ignored. With `cfg_lsb_first`=0 the sample is sent MSB first starting at slot bit 0.
- R8: The slot length code `cfg_clen` (same encoding as R7) sets bits per slot. When the slot is longer than the sample, the remaining slot bits are 0.
- R9: When the sample is longer than the slot, only its first slot-length bits in transmit order are sent, and the rest are dropped.
- R10: With `cfg_lsb_first`=1 the sample is sent from bit 0 upward, followed by zero padding.
- R11: `cfg_slots` (0,1,2,3 → 2,4,6,8 slots per frame) sets the frame size. `s_ready` is high for one cycle at each slot start, and accepted words fill consecutive slots in slot order across frames.
- R12: If `s_valid` is low when a slot starts, the whole slot is sent as zeros, no word is consumed, and `underrun` pulses for one cycle together with that slot's first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 PCM A, 3 PCM B |
| cfg_dlen | input | 2 | Sample length code: 16/20/24/32 bits |
| cfg_clen | input | 2 | Slot length code: 16/20/24/32 bits |
| cfg_slots | input | 2 | Slots per frame code: 2/4/6/8 |
| cfg_bclk_inv | input | 1 | Invert the bit clock pin |
| cfg_lsb_first | input | 1 | Send sample LSB first |
| cfg_div | input | DIV_W | Half bit-clock period minus one, in system cycles |
| s_valid | input | 1 | Sample word valid |
| s_data | input | 32 | Sample word, right-aligned |
| s_ready | output | 1 | Sample taken this cycle (slot start) |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select / frame sync |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Pulse: a slot began with no valid sample |

## Verification
Several checks can only be seen across a frame boundary. The PCM A sync pulse sits in the final bit of the previous frame, and the I2S word select looks two bit positions ahead and wraps into the next frame. An underrun only shows once the stream runs dry partway through a frame. Each scenario therefore captures two or three whole frames at the bit-clock launch edges and compares every bit with a model built from the requirements. The stimulus stacks up deliberate mismatches: a slot longer than the sample, a sample longer than the slot, a word source that runs out after three words in a four-slot frame, and an inverted clock combined with LSB-first order.

// File: rtl/tdm_tx_pkg.sv
`timescale 1ns/1ps
package tdm_tx_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LJ    = 2'd1,
    FMT_PCM_A = 2'd2,
    FMT_PCM_B = 2'd3
  } fmt_e;

  // length code -> bit count (16, 20, 24, 32)
  function automatic logic [5:0] len_of(input logic [1:0] code);
    case (code)
      2'd0:    len_of = 6'd16;
      2'd1:    len_of = 6'd20;
      2'd2:    len_of = 6'd24;
      default: len_of = 6'd32;
    endcase
  endfunction

  // slot code -> slots per frame (2, 4, 6, 8)
  function automatic logic [3:0] slots_of(input logic [1:0] code);
    slots_of = {1'b0, code, 1'b0} + 4'd2;
  endfunction

endpackage

// File: rtl/tdm_tx_clkdiv.sv
`timescale 1ns/1ps
module tdm_tx_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_half,
  input  logic             inv,
  output logic             bit_tick,
  output logic             bclk_pin
);

  logic [DIV_W-1:0] cnt;
  logic             phase;
  logic             wrap;

  assign wrap     = (cnt >= div_half);
  // a new bit period starts when the high phase ends
  assign bit_tick = wrap & phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      phase    <= 1'b0;
      bclk_pin <= inv;
    end else if (wrap) begin
      cnt      <= '0;
      phase    <= ~phase;
      bclk_pin <= (~phase) ^ inv;
    end else begin
      cnt      <= cnt + 1'b1;
      bclk_pin <= phase ^ inv;
    end
  end

  AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (rst)
    $stable(inv) |=> (bclk_pin == (phase ^ inv)));  // R2

endmodule

// File: rtl/tdm_tx_framer.sv
`timescale 1ns/1ps
module tdm_tx_framer
  import tdm_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  fmt_e       fmt,
  input  logic [1:0] clen_code,
  input  logic [1:0] slots_code,
  output logic       slot_start,
  output logic       ws
);

  logic [5:0] clen;
  logic [3:0] nsl, half;
  logic [5:0] bit_i, nbit;
  logic [3:0] slot_i, nslot, nnslot;
  logic       last_bit, last_slot, n_last_bit, n_last_slot;
  logic       ws_next;

  assign clen = len_of(clen_code);
  assign nsl  = slots_of(slots_code);
  assign half = nsl >> 1;

  // position of the bit about to be launched
  assign last_bit  = (bit_i >= clen - 6'd1);
  assign last_slot = (slot_i >= nsl - 4'd1);
  assign nbit      = last_bit ? 6'd0 : bit_i + 6'd1;
  assign nslot     = last_bit ? (last_slot ? 4'd0 : slot_i + 4'd1) : slot_i;

  // one position further on, for the early word select
  assign n_last_bit  = (nbit >= clen - 6'd1);
  assign n_last_slot = (nslot >= nsl - 4'd1);
  assign nnslot      = n_last_bit ? (n_last_slot ? 4'd0 : nslot + 4'd1) : nslot;

  assign slot_start = tick & (nbit == 6'd0);

  always_comb begin
    case (fmt)
      FMT_I2S:   ws_next = (nnslot >= half);
      FMT_LJ:    ws_next = (nslot >= half);
      FMT_PCM_A: ws_next = n_last_slot & n_last_bit;
      default:   ws_next = (nslot == 4'd0) & (nbit == 6'd0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_i  <= '1;
      slot_i <= '1;
      ws     <= 1'b0;
    end else if (tick) begin
      bit_i  <= nbit;
      slot_i <= nslot;
      ws     <= ws_next;
    end
  end

  AST_WS_ON_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    !$stable(ws) |-> $past(tick));  // R3

  AST_PCMB_PULSE_AT_START: assert property (@(posedge clk) disable iff (rst)
    (fmt == FMT_PCM_B) && $rose(ws) |-> (bit_i == 6'd0) && (slot_i == 4'd0));  // R6

endmodule

// File: rtl/tdm_tx_shifter.sv
`timescale 1ns/1ps
module tdm_tx_shifter
  import tdm_tx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         slot_start,
  input  logic [1:0]   dlen_code,
  input  logic         lsb_first,
  input  logic         s_valid,
  input  logic [W-1:0] s_data,
  output logic         s_ready,
  output logic         sd,
  output logic         underrun
);

  logic [5:0]   dlen, pad;
  logic [W-1:0] mask, masked, rev, aligned, fill, shreg;

  assign dlen   = len_of(dlen_code);
  assign pad    = 6'(W) - dlen;
  assign mask   = {W{1'b1}} >> pad;
  assign masked = s_data & mask;

  for (genvar g = 0; g < W; g++) begin : g_rev
    assign rev[g] = masked[W-1-g];
  end

  // left-align so that the first bit to send sits in the top position
  assign aligned = lsb_first ? rev : (masked << pad);
  assign fill    = s_valid ? aligned : '0;
  assign s_ready = slot_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      sd       <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= slot_start & ~s_valid;
      if (slot_start) begin
        sd    <= fill[W-1];
        shreg <= fill << 1;
      end else if (tick) begin
        sd    <= shreg[W-1];
        shreg <= shreg << 1;
      end
    end
  end

  AST_SD_ON_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd) |-> $past(tick));  // R2

  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> tick);  // R11

  AST_STARVED_SILENT: assert property (@(posedge clk) disable iff (rst)
    underrun |-> !sd);  // R12

endmodule

// File: rtl/tdm_serial_tx.sv
`timescale 1ns/1ps
module tdm_serial_tx
  import tdm_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_fmt,
  input  logic [1:0]       cfg_dlen,
  input  logic [1:0]       cfg_clen,
  input  logic [1:0]       cfg_slots,
  input  logic             cfg_bclk_inv,
  input  logic             cfg_lsb_first,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             s_valid,
  input  logic [31:0]      s_data,
  output logic             s_ready,
  output logic             bclk,
  output logic             ws,
  output logic             sd,
  output logic             underrun
);

  logic bit_tick;
  logic slot_start;
  fmt_e fmt;

  assign fmt = fmt_e'(cfg_fmt);

  tdm_tx_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
    .clk      (clk),
    .rst      (rst),
    .div_half (cfg_div),
    .inv      (cfg_bclk_inv),
    .bit_tick (bit_tick),
    .bclk_pin (bclk)
  );

  tdm_tx_framer i_framer (
    .clk        (clk),
    .rst        (rst),
    .tick       (bit_tick),
    .fmt        (fmt),
    .clen_code  (cfg_clen),
    .slots_code (cfg_slots),
    .slot_start (slot_start),
    .ws         (ws)
  );

  tdm_tx_shifter #(.W(WORD_W)) i_shifter (
    .clk        (clk),
    .rst        (rst),
    .tick       (bit_tick),
    .slot_start (slot_start),
    .dlen_code  (cfg_dlen),
    .lsb_first  (cfg_lsb_first),
    .s_valid    (s_valid),
    .s_data     (s_data),
    .s_ready    (s_ready),
    .sd         (sd),
    .underrun   (underrun)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !s_ready && !underrun);  // R1

endmodule

// File: tb/test_tdm_serial_tx.sv
`timescale 1ns/1ps
module test_tdm_serial_tx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_fmt = 2'd0, cfg_dlen = 2'd0, cfg_clen = 2'd0, cfg_slots = 2'd0;
  logic        cfg_inv = 1'b0, cfg_lsb = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic        s_valid;
  logic [31:0] s_data;
  logic        s_ready, bclk, ws, sd, underrun;

  always #2 clk = ~clk;

  tdm_serial_tx #(.DIV_W(8)) i_tdm_serial_tx (
    .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_dlen(cfg_dlen), .cfg_clen(cfg_clen),
    .cfg_slots(cfg_slots), .cfg_bclk_inv(cfg_inv), .cfg_lsb_first(cfg_lsb),
    .cfg_div(cfg_div), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .bclk(bclk), .ws(ws), .sd(sd), .underrun(underrun)
  );

  int n_total = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] words [0:63];
  int nw = 0;
  int idx = 0;
  int nb_target = 0, ncap = 0, nunder = 0, cyc = 0, t_first = 0, t_second = 0;
  bit cap_sd [0:1023];
  bit cap_ws [0:1023];

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_total++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // stream source
  initial begin
    bit take;
    s_valid = 1'b0;
    s_data  = '0;
    forever begin
      @(negedge clk);
      take = s_ready && s_valid;
      @(posedge clk);
      #1;
      if (rst) idx = 0;
      else if (take) idx++;
      s_valid = (idx < nw);
      s_data  = (idx < nw) ? words[idx] : 32'h0;
    end
  end

  // capture at each launch edge of the bit clock
  initial begin
    logic prev_lvl, lvl;
    prev_lvl = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (rst) begin
        ncap = 0; nunder = 0; prev_lvl = 1'b0;
      end else begin
        lvl = bclk ^ cfg_inv;
        if (prev_lvl && !lvl && ncap < nb_target) begin
          cap_sd[ncap] = sd;
          cap_ws[ncap] = ws;
          if (underrun) nunder++;
          if (ncap == 0) t_first = cyc;
          if (ncap == 1) t_second = cyc;
          ncap++;
        end
        prev_lvl = lvl;
      end
    end
  end

  function automatic int lenv(input logic [1:0] c);
    return (c == 2'd3) ? 32 : 16 + 4 * int'(c);
  endfunction

  function automatic bit exp_sd(input int k);
    int cl, dl, w, b, mn;
    cl = lenv(cfg_clen); dl = lenv(cfg_dlen);
    w = k / cl; b = k % cl;
    mn = (dl < cl) ? dl : cl;
    if (w >= nw || b >= mn) return 1'b0;
    return cfg_lsb ? words[w][b] : words[w][dl-1-b];
  endfunction

  function automatic bit exp_ws(input int k);
    int cl, ns, kk, sl, b;
    cl = lenv(cfg_clen); ns = 2 * int'(cfg_slots) + 2;
    kk = (cfg_fmt == 2'd0) ? k + 1 : k;
    sl = (kk / cl) % ns; b = kk % cl;
    case (cfg_fmt)
      2'd0, 2'd1: return sl >= ns / 2;
      2'd2:       return (sl == ns - 1) && (b == cl - 1);
      default:    return (sl == 0) && (b == 0);
    endcase
  endfunction

  task automatic run_case(input string sd_tag, input string ws_tag,
                          input int fmt, input int dl, input int cl, input int sl,
                          input bit inv, input bit lsb, input int div,
                          input int nwords, input int frames);
    int nslots, nbits, bad_sd, bad_ws, exp_under, guard;
    rst = 1'b1;
    cfg_fmt = 2'(fmt); cfg_dlen = 2'(dl); cfg_clen = 2'(cl); cfg_slots = 2'(sl);
    cfg_inv = inv; cfg_lsb = lsb; cfg_div = 8'(div);
    nw = nwords;
    for (int i = 0; i < 64; i++) words[i] = 32'(32'h9E3779B9 * 32'(i + 3 + fmt)) ^ 32'hC3A55A3C;
    nslots = frames * (2 * sl + 2);
    nbits  = nslots * lenv(2'(cl));
    nb_target = nbits;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    guard = 0;
    while (ncap < nbits && guard < 30000) begin
      @(posedge clk);
      guard++;
    end
    #2;
    check(sd_tag, "capture completed", ncap, nbits);
    bad_sd = 0; bad_ws = 0;
    for (int k = 0; k < nbits; k++) begin
      if (cap_sd[k] != exp_sd(k)) bad_sd++;
      if (cap_ws[k] != exp_ws(k)) bad_ws++;
    end
    check(sd_tag, "serial data mismatches", bad_sd, 0);
    check(ws_tag, "word select mismatches", bad_ws, 0);
    check("R2", "bit period in system cycles", t_second - t_first, 2 * (div + 1));
    exp_under = (nslots > nwords) ? nslots - nwords : 0;
    check("R12", "underrun pulses", nunder, exp_under);
  endtask

  task automatic t_reset;
    rst = 1'b1; cfg_inv = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "bclk idle level inverted", bclk, 1);
    check("R1", "sd in reset", sd, 0);
    check("R1", "ws in reset", ws, 0);
    check("R1", "s_ready in reset", s_ready, 0);
    check("R1", "underrun in reset", underrun, 0);
    cfg_inv = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2", "bclk idle level normal", bclk, 0);
  endtask

  // two-slot I2S, 16-bit samples in 16-bit slots, upper s_data bits ignored
  task automatic t_i2s_stereo;
    run_case("R7", "R3", 0, 0, 0, 0, 1'b0, 1'b0, 1, 32, 3);
  endtask

  // left-justified, four slots of 24 bits
  task automatic t_lj_tdm4;
    run_case("R11", "R4", 1, 2, 2, 1, 1'b0, 1'b0, 0, 32, 2);
  endtask

  // PCM A, six 32-bit slots holding 20-bit samples (padding)
  task automatic t_pcma_tdm6_pad;
    run_case("R8", "R5", 2, 1, 3, 2, 1'b0, 1'b0, 0, 32, 2);
  endtask

  // PCM B, eight 16-bit slots holding 32-bit samples (truncation)
  task automatic t_pcmb_tdm8_trunc;
    run_case("R9", "R6", 3, 3, 0, 3, 1'b0, 1'b0, 0, 32, 2);
  endtask

  // I2S with inverted bit clock and LSB-first order
  task automatic t_lsb_inverted;
    run_case("R10", "R3", 0, 2, 3, 0, 1'b1, 1'b1, 2, 32, 2);
  endtask

  // left-justified four-slot frame whose source runs dry after three words
  task automatic t_underflow;
    run_case("R12", "R4", 1, 0, 0, 1, 1'b0, 1'b0, 0, 3, 2);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_total++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_i2s_stereo;
    t_lj_tdm4;
    t_pcma_tdm6_pad;
    t_pcmb_tdm8_trunc;
    t_lsb_inverted;
    t_underflow;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

endmodule